// File: doc/BRIEF.md
# In-Place Insertion Sorter

This block sorts the first N words of a single-port synchronous data memory into ascending unsigned order, in place, using an insertion sort. A pulse on `start` samples the word count. The block then works through the memory one element at a time. Each new element is held in a register while larger neighbours below it are shifted up one slot. The element is then dropped into the gap that is left.

The controller steps through a fixed eight-state schedule. An outer group of states initialises the index, tests for completion and fetches the next key. An inner group of four states walks downward, reading and comparing, then writing and decrementing. A final state places the key. Reads and writes use separate address registers.

The memory is assumed to return read data one cycle after the address is presented. When the sort finishes, `done` pulses for one cycle. A `start` that arrives while a sort is running is ignored.

Top module: `inplace_isort`

## Requirements
- R1: While reset is held and directly after it, `done` and `mem_we` are both 0.
- R2: When `done` rises after a start with count N, memory words 0 to N-1 hold the original first N words, sorted in ascending unsigned order.
- R3: Memory words at addresses N and above are never altered by a sort.
- R4: A count of 0 or 1 completes without any memory write.
- R5: `done` is high for exactly one cycle per sort, and only in the cycle after the completion test succeeds.
- R6: A `start` pulse that arrives while a sort is running has no effect: the running sort completes normally and produces only one `done` pulse.
- R7: The count is sampled only in the cycle in which `start` is accepted. Changing the `count` input during a sort does not change the result or the timing.
- R8: Every memory write goes to an address below the sampled count.
- R9: If `start` is accepted at clock edge e0, `done` is first high after edge e0 + 2 + 6*max(N-1,0) + 4*P, where P is the number of inverted pairs in the input. The sort issues exactly max(N-1,0) + P memory writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sort; accepted only while idle |
| count | input | AW+1 | Number of words to sort, sampled when start is accepted |
| done | output | 1 | One-cycle pulse when the sort is finished |
| mem_addr | output | AW | Memory address for a read or a write |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | DW | Memory read data, valid one cycle after its address |

## Verification
Two situations are hard to reach from the ports. The first is an inner walk that runs all the way to index -1, ending with a write to address 0. The second is a sort of the full memory depth, where the outer index reaches 2^AW. Reverse-ordered arrays of the full length drive both situations, and the exact cycle and write counts expose any off-by-one error. Interference while a sort is busy is also hard to provoke. Some runs therefore pulse `start` and change `count` part way through, then confirm that the sort still completes with one `done` and the original timing.

// File: rtl/isort_pkg.sv
package isort_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INIT,   // S1: outer index := 1
    ST_OTEST,  // S2: outer exit test, set up i and read address
    ST_FETCH,  // S3: bump j, capture key
    ST_SETRD,  // S4: read address := i
    ST_READ,   // S5: memory read in flight
    ST_TEST,   // S6: capture data, write address := i+1, compare
    ST_SHIFT,  // S7: write data upward, i := i-1
    ST_PLACE   // S8: write key into the gap
  } isort_state_e;
endpackage

// File: rtl/isort_ctrl.sv
module isort_ctrl
  import isort_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         outer_exit,
  input  logic         inner_go,
  output isort_state_e state,
  output logic         done
);

  isort_state_e state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (start) state_nx = ST_INIT;
      ST_INIT:  state_nx = ST_OTEST;
      ST_OTEST: state_nx = outer_exit ? ST_IDLE : ST_FETCH;
      ST_FETCH: state_nx = ST_SETRD;
      ST_SETRD: state_nx = ST_READ;
      ST_READ:  state_nx = ST_TEST;
      ST_TEST:  state_nx = inner_go ? ST_SHIFT : ST_PLACE;
      ST_SHIFT: state_nx = ST_SETRD;
      ST_PLACE: state_nx = ST_OTEST;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_nx;
      done  <= (state == ST_OTEST) && outer_exit;
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(state) == ST_OTEST);
  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && start) |=> state != ST_INIT);

endmodule

// File: rtl/isort_dpath.sv
module isort_dpath
  import isort_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  isort_state_e  state,
  input  logic          start,
  input  logic [AW:0]   count,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          outer_exit,
  output logic          inner_go
);

  localparam logic signed [AW:0] ONE_S = 1;
  localparam logic        [AW:0] ONE_U = 1;

  logic        [AW:0]   n_q;
  logic        [AW:0]   j_q;
  logic signed [AW:0]   i_q;
  logic        [DW-1:0] temp_q;
  logic        [DW-1:0] data_q;
  logic        [AW-1:0] raddr_q;
  logic        [AW-1:0] waddr_q;

  // slot above the current inner index
  function automatic logic [AW-1:0] place_slot(input logic signed [AW:0] idx);
    logic [AW:0] s;
    s = idx + ONE_S;
    return s[AW-1:0];
  endfunction

  // keep shifting while the key is smaller and the index is not negative
  function automatic logic shift_on(input logic [DW-1:0] key,
                                    input logic [DW-1:0] val,
                                    input logic signed [AW:0] idx);
    return !idx[AW] && (key < val);
  endfunction

  assign outer_exit = (n_q <= j_q);
  assign inner_go   = shift_on(temp_q, mem_rdata, i_q);

  always_comb begin
    mem_addr  = raddr_q;
    mem_wdata = data_q;
    mem_we    = 1'b0;
    case (state)
      ST_OTEST: mem_addr = j_q[AW-1:0];
      ST_SHIFT: begin
        mem_addr = waddr_q;
        mem_we   = 1'b1;
      end
      ST_PLACE: begin
        mem_addr  = waddr_q;
        mem_wdata = temp_q;
        mem_we    = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q     <= '0;
      j_q     <= '0;
      i_q     <= '0;
      temp_q  <= '0;
      data_q  <= '0;
      raddr_q <= '0;
      waddr_q <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (start) n_q <= count;
        ST_INIT:  j_q <= ONE_U;
        ST_OTEST: if (!outer_exit) begin
          i_q     <= $signed(j_q - ONE_U);
          raddr_q <= j_q[AW-1:0];
        end
        ST_FETCH: begin
          j_q    <= j_q + ONE_U;
          temp_q <= mem_rdata;
        end
        ST_SETRD: raddr_q <= i_q[AW-1:0];
        ST_TEST: begin
          data_q  <= mem_rdata;
          waddr_q <= place_slot(i_q);
        end
        ST_SHIFT: i_q <= i_q - ONE_S;
        default: ;
      endcase
    end
  end

  // R8
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ({1'b0, mem_addr} < n_q));
  // R2
  i_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i_q >= -1);
  // R2
  shift_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SHIFT |-> !i_q[AW]);
  // R7
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && state != ST_INIT) |-> $stable(n_q));
  // R3
  fetch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FETCH |-> j_q < n_q);

endmodule

// File: rtl/inplace_isort.sv
module inplace_isort
  import isort_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW:0]   count,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata
);

  isort_state_e state;
  logic         outer_exit;
  logic         inner_go;

  isort_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .outer_exit (outer_exit),
    .inner_go   (inner_go),
    .state      (state),
    .done       (done)
  );

  isort_dpath #(.DW(DW), .AW(AW)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .start      (start),
    .count      (count),
    .mem_rdata  (mem_rdata),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .outer_exit (outer_exit),
    .inner_go   (inner_go)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !mem_we);

endmodule

// File: tb/inplace_isort_test.sv
module inplace_isort_test;
  localparam int CLK_NS = 10;
  localparam int DW = 16;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [AW:0]   count;
  logic          done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;

  logic [DW-1:0] ram [DEPTH];
  logic          ld_we;
  logic [AW-1:0] ld_addr;
  logic [DW-1:0] ld_data;

  int checks = 0;
  int errors = 0;
  int wr_cnt, done_cnt, bad_addr, cur_n;
  int vals [DEPTH];
  int expv [DEPTH];
  int seed_word;

  always #(CLK_NS / 2) clk = ~clk;

  inplace_isort #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count), .done(done),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (ld_we) ram[ld_addr] <= ld_data;
    else if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      wr_cnt <= wr_cnt + 1;
      if (int'(mem_addr) >= cur_n) bad_addr <= bad_addr + 1;
    end
    if (rst_n && done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int inversions(input int n);
    int p = 0;
    for (int a = 0; a < n; a++)
      for (int b = a + 1; b < n; b++)
        if (vals[a] > vals[b]) p++;
    return p;
  endfunction

  function automatic void ref_sort(input int n);
    for (int k = 0; k < DEPTH; k++) expv[k] = vals[k];
    for (int pass = 0; pass < n; pass++)
      for (int k = 0; k + 1 < n - pass; k++)
        if (expv[k] > expv[k + 1]) begin
          int t = expv[k];
          expv[k] = expv[k + 1];
          expv[k + 1] = t;
        end
  endfunction

  // mode: 0 random, 1 ascending, 2 descending, 3 narrow range duplicates, 4 all equal
  task automatic run_sort(input int n, input int mode, input bit disturb);
    int inv, cyc, exp_cyc, base, ok_words, bad_keep;
    bit timed_out;
    for (int k = 0; k < DEPTH; k++) begin
      case (mode)
        1: vals[k] = 100 + 3 * k;
        2: vals[k] = 2000 - 5 * k;
        3: vals[k] = $urandom_range(0, 4);
        4: vals[k] = 77;
        default: vals[k] = $urandom_range(0, (1 << DW) - 1);
      endcase
    end
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = AW'(k); ld_data = DW'(vals[k]);
    end
    @(negedge clk);
    ld_we = 1'b0;
    ref_sort(n);
    inv = inversions(n);
    base = (n > 1) ? n - 1 : 0;
    exp_cyc = 3 + 6 * base + 4 * inv;
    wr_cnt = 0; done_cnt = 0; bad_addr = 0; cur_n = n;
    count = (AW + 1)'(n);
    start = 1'b1;
    cyc = 0;
    timed_out = 1'b0;
    while (1) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (cyc == 1) start = 1'b0;
      if (disturb && cyc == 4) begin
        start = 1'b1;
        count = (AW + 1)'($urandom_range(0, DEPTH));
      end
      if (disturb && cyc == 5) start = 1'b0;
      if (done) break;
      if (cyc > 20000) begin timed_out = 1'b1; break; end
    end
    chk(!timed_out, "R9 sort finished", cyc, exp_cyc);
    chk(cyc == exp_cyc, "R9 cycles to done", cyc, exp_cyc);
    chk(wr_cnt == base + inv, "R9 write count", wr_cnt, base + inv);
    if (n <= 1) chk(wr_cnt == 0, "R4 no writes for tiny count", wr_cnt, 0);
    ok_words = 0; bad_keep = 0;
    for (int k = 0; k < DEPTH; k++) begin
      if (k < n) begin
        if (int'(ram[k]) == expv[k]) ok_words++;
        else $display("FAIL R2 word %0d actual %0d expected %0d", k, ram[k], expv[k]);
      end else if (int'(ram[k]) != vals[k]) begin
        bad_keep++;
        $display("FAIL R3 word %0d actual %0d expected %0d", k, ram[k], vals[k]);
      end
    end
    chk(ok_words == n, "R2 sorted words", ok_words, n);
    chk(bad_keep == 0, "R3 words above count kept", bad_keep, 0);
    chk(bad_addr == 0, "R8 write addresses below count", bad_addr, 0);
    @(negedge clk);
    chk(done == 1'b0, "R5 done width", int'(done), 0);
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, disturb ? "R6 R7 single done under interference" : "R5 single done",
        done_cnt, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    seed_word = $urandom(1234);
    rst_n = 1'b0; start = 1'b0; count = '0;
    ld_we = 1'b0; ld_addr = '0; ld_data = '0;
    wr_cnt = 0; done_cnt = 0; bad_addr = 0; cur_n = 0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && mem_we == 1'b0, "R1 quiet in reset", int'({done, mem_we}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done == 1'b0 && mem_we == 1'b0, "R1 quiet after reset", int'({done, mem_we}), 0);

    run_sort(0, 0, 1'b0);
    run_sort(1, 2, 1'b0);
    run_sort(2, 2, 1'b0);
    run_sort(DEPTH, 2, 1'b0);
    run_sort(DEPTH, 1, 1'b0);
    run_sort(DEPTH, 4, 1'b0);
    run_sort(16, 3, 1'b1);
    run_sort(DEPTH, 2, 1'b1);
    for (int r = 0; r < 20; r++) begin
      int n = $urandom_range(0, DEPTH);
      run_sort(n, $urandom_range(0, 4), (n >= 3) && ($urandom_range(0, 1) == 1));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule